// File: doc/BRIEF.md
# Start And Shortening ID Detector

This block watches the per-field ID bits of a recorder-type audio stream and reports two events to a host: a start marker and a shortening marker. It only acts while the received category code identifies that kind of source. A marker counts only when the field's sync bit is also set.

When a marker is accepted, the block pulls the active-low ready strobe low for a fixed number of cycles. It also loads an 81-bit result word that encodes which marker was seen. The same strobe and result register are shared with the subcode Q path. A Q frame that arrives on `q_stb` also loads the word and pulses the strobe. The host always reads the word left by the most recent event.

The host asks for the word with a one-cycle read request carrying the Q read address. The block then shifts the word out serially, one bit per cycle, with a valid qualifier.

Top module: `sid_detector`

## Requirements
- R1: After reset, `rdy_n` is 1, `sdo_valid` is 0 and no read is in progress.
- R2: Markers are accepted only when `cat_code[7:1]` equals 7'b1100000; `cat_code[0]` is ignored. Any other code produces no strobe and leaves the result word unchanged.
- R3: A field with `id_sync`=1 and `id_start`=1 is a start marker and loads the result word as all ones: flag 1 and data bits all 1.
- R4: A field with `id_sync`=1, `id_short`=1 and `id_start`=0 is a shortening marker and loads the result word as all zeros: flag 0 and data bits all 0.
- R5: A field with `id_sync`=0 is never a marker, whatever its other ID bits are.
- R6: When `id_start` and `id_short` are both 1 with sync, the field counts as a start marker.
- R7: After a marker is accepted, the detector stays disarmed until a field arrives that is not a marker. Repeated marker fields therefore give a single strobe. The next marker after a non-marker field strobes again.
- R8: Every accepted event drives `rdy_n` low for exactly STB_CYCLES (default 4) cycles, starting the cycle after the event's input strobe.
- R9: A `rd_req` with `rd_addr` equal to RD_ADDR (default 8'h30) starts a readout in the next cycle. The readout holds `sdo_valid` high for 81 cycles and shifts the flag first (word bit 0), then data bits 0 to 79. A request with any other address, or while a readout is running, has no effect.
- R10: A `q_stb` pulse loads the word with `q_crc_ok` as the flag and `q_data` as the data (data bit i at word bit i+1). It also produces the R8 strobe. The most recent event supplies the word.
- R11: If `q_stb` and an accepted marker occur in the same cycle, the marker's word is stored.
- R12: An event that arrives during a readout does not alter the bits being shifted out. It does replace the word for the next readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cat_code | input | 8 | Received category code; bit 0 is the L bit |
| id_stb | input | 1 | One-cycle strobe marking a new field's ID bits |
| id_sync | input | 1 | Sync bit of the field |
| id_start | input | 1 | Start-marker bit of the field |
| id_short | input | 1 | Shortening-marker bit of the field |
| q_stb | input | 1 | One-cycle strobe: a complete subcode Q frame is present |
| q_data | input | 80 | Subcode Q payload |
| q_crc_ok | input | 1 | CRC result of that Q frame |
| rd_req | input | 1 | One-cycle host read request |
| rd_addr | input | 8 | Host read address |
| rdy_n | output | 1 | Active-low ready strobe |
| sdo | output | 1 | Serial result data |
| sdo_valid | output | 1 | High while `sdo` carries a result bit |

## Verification
The bench holds a marker on for several fields. A detector without re-arm logic would strobe on each of those fields instead of once. It sends fields with both marker bits set, where a reversed priority would return an all-zero word. It applies non-matching category codes and fields without sync, which a loose decoder would wrongly accept. It also injects a Q frame in the same cycle as a marker, and another one partway through a readout. A wrong arbiter would store the Q word in the first case. A shared shift register would corrupt the bits already leaving in the second. Readouts are compared bit for bit, so a reversed shift order or a dropped flag shows up as a word mismatch.

// File: rtl/sid_detector_pkg.sv
// Package: shared kinds and constants of the start/shortening ID detector.
// Assumes: the result word is one flag bit followed by the Q payload width.
package sid_detector_pkg;

    // Kind of an accepted ID event.
    typedef enum logic [1:0] {
        ID_NONE  = 2'd0,
        ID_START = 2'd1,
        ID_SHORT = 2'd2
    } id_kind_t;

    // Upper seven category bits that enable detection (the L bit is free).
    localparam logic [6:0] CAT_ENABLE = 7'b1100000;

endpackage

// File: rtl/sid_id_match.sv
// Module: sid_id_match
// Decides, per field strobe, whether a start or shortening marker is accepted.
// Assumes: ID bits and category code are valid in the cycle id_stb is high.
// A marker is accepted only while armed; a non-marker field re-arms.
module sid_id_match
    import sid_detector_pkg::*;
#(
    parameter int CAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAT_W-1:0] cat_code,
    input  logic             id_stb,
    input  logic             id_sync,
    input  logic             id_start,
    input  logic             id_short,
    output logic             evt,
    output id_kind_t         kind
);

    logic cat_ok;
    logic hit;
    logic armed_q;

    // Category gate: compare the upper bits, ignore the L bit.
    always_comb begin
        cat_ok = (cat_code[CAT_W-1:CAT_W-7] == CAT_ENABLE);
    end

    // Classify the field; start wins over shortening.
    always_comb begin
        hit  = cat_ok && id_sync && (id_start || id_short);
        kind = ID_NONE;
        if (hit) begin
            kind = id_start ? ID_START : ID_SHORT;
        end
        evt = id_stb && hit && armed_q;
    end

    // Arm state: cleared by an accepted marker, set again by a non-marker field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (id_stb) begin
            if (!hit) begin
                armed_q <= 1'b1;
            end else if (armed_q) begin
                armed_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sid_result_sel.sv
// Module: sid_result_sel
// Holds the result word of the most recent event and drives the ready strobe.
// Assumes: an ID event and a Q frame in the same cycle resolve to the ID word.
module sid_result_sel
    import sid_detector_pkg::*;
#(
    parameter int Q_W        = 80,
    parameter int STB_CYCLES = 4,
    localparam int WORD_W    = Q_W + 1,
    localparam int CNT_W     = $clog2(STB_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_evt,
    input  id_kind_t          id_kind,
    input  logic              q_stb,
    input  logic [Q_W-1:0]    q_data,
    input  logic              q_crc_ok,
    output logic [WORD_W-1:0] word,
    output logic              rdy_n
);

    logic [CNT_W-1:0] stb_cnt_q;
    logic             load;
    logic [WORD_W-1:0] next_word;

    // Pick the incoming word: marker first, then Q frame.
    always_comb begin
        load      = id_evt || q_stb;
        next_word = {q_data, q_crc_ok};
        if (id_evt) begin
            next_word = (id_kind == ID_START) ? {WORD_W{1'b1}} : {WORD_W{1'b0}};
        end
    end

    // Result register: replaced by every event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (load) begin
            word <= next_word;
        end
    end

    // Strobe length counter: restarts on every event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_cnt_q <= '0;
        end else if (load) begin
            stb_cnt_q <= CNT_W'(STB_CYCLES);
        end else if (stb_cnt_q != '0) begin
            stb_cnt_q <= stb_cnt_q - 1'b1;
        end
    end

    // Ready strobe is low while the counter runs.
    always_comb begin
        rdy_n = (stb_cnt_q == '0);
    end

endmodule

// File: rtl/sid_serial_out.sv
// Module: sid_serial_out
// Shifts a snapshot of the result word out LSB first on a valid read request.
// Assumes: requests during a running readout are dropped.
module sid_serial_out #(
    parameter int WORD_W = 81,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] RD_ADDR = 8'h30,
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] word,
    output logic              sdo,
    output logic              sdo_valid
);

    logic [WORD_W-1:0] shreg_q;
    logic [BIT_W-1:0]  bit_q;
    logic              busy_q;
    logic              start;

    // Accept a request only for our address and while idle.
    always_comb begin
        start = rd_req && (rd_addr == RD_ADDR) && !busy_q;
    end

    // Snapshot, shift and bit count of the readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= '0;
            busy_q  <= 1'b0;
        end else if (start) begin
            shreg_q <= word;
            bit_q   <= '0;
            busy_q  <= 1'b1;
        end else if (busy_q) begin
            if (bit_q == BIT_W'(WORD_W - 1)) begin
                busy_q <= 1'b0;
            end else begin
                shreg_q <= {1'b0, shreg_q[WORD_W-1:1]};
                bit_q   <= bit_q + 1'b1;
            end
        end
    end

    // Serial outputs.
    always_comb begin
        sdo       = busy_q & shreg_q[0];
        sdo_valid = busy_q;
    end

endmodule

// File: rtl/sid_detector.sv
// Module: sid_detector (top)
// Start/shortening ID detector sharing its strobe and readout with subcode Q.
// Assumes: all inputs are synchronous to clk; strobes are one cycle wide.
module sid_detector
    import sid_detector_pkg::*;
#(
    parameter int CAT_W      = 8,
    parameter int Q_W        = 80,
    parameter int ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] RD_ADDR = 8'h30,
    parameter int STB_CYCLES = 4,
    localparam int WORD_W    = Q_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CAT_W-1:0]  cat_code,
    input  logic              id_stb,
    input  logic              id_sync,
    input  logic              id_start,
    input  logic              id_short,
    input  logic              q_stb,
    input  logic [Q_W-1:0]    q_data,
    input  logic              q_crc_ok,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rdy_n,
    output logic              sdo,
    output logic              sdo_valid
);

    logic              id_evt;
    id_kind_t          id_kind;
    logic [WORD_W-1:0] word;

    sid_id_match #(.CAT_W(CAT_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .cat_code (cat_code),
        .id_stb   (id_stb),
        .id_sync  (id_sync),
        .id_start (id_start),
        .id_short (id_short),
        .evt      (id_evt),
        .kind     (id_kind)
    );

    sid_result_sel #(.Q_W(Q_W), .STB_CYCLES(STB_CYCLES)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_evt   (id_evt),
        .id_kind  (id_kind),
        .q_stb    (q_stb),
        .q_data   (q_data),
        .q_crc_ok (q_crc_ok),
        .word     (word),
        .rdy_n    (rdy_n)
    );

    sid_serial_out #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .RD_ADDR(RD_ADDR)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .word      (word),
        .sdo       (sdo),
        .sdo_valid (sdo_valid)
    );

endmodule

// File: rtl/sid_detector_chk.sv
// Module: sid_detector_chk
// Property checker for sid_detector, attached by bind.
module sid_detector_chk #(
    parameter int CAT_W      = 8,
    parameter int ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] RD_ADDR = 8'h30,
    parameter int STB_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CAT_W-1:0]  cat_code,
    input logic              id_stb,
    input logic              id_sync,
    input logic              q_stb,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              id_evt,
    input logic              rdy_n,
    input logic              sdo_valid
);

    logic        cat_bad;
    logic        rd_hit;
    int unsigned low_run;

    always_comb begin
        cat_bad = (cat_code[CAT_W-1:CAT_W-7] != 7'b1100000);
        rd_hit  = rd_req && (rd_addr == RD_ADDR);
    end

    // Length of the current low phase of the ready strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     low_run <= 0;
        else if (!rdy_n) low_run <= low_run + 1;
        else            low_run <= 0;
    end

    AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= STB_CYCLES);                                          // R8
    AST_Q_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        q_stb |=> !rdy_n);                                               // R10
    AST_EVT_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        id_evt |=> !rdy_n);                                              // R8
    AST_CAT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_stb && cat_bad) |-> !id_evt);                                // R2
    AST_SYNC_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        (id_stb && !id_sync) |-> !id_evt);                               // R5
    AST_READ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !sdo_valid) |=> sdo_valid);                           // R9
    AST_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hit && !sdo_valid) |=> !sdo_valid);                         // R9

endmodule

bind sid_detector sid_detector_chk #(
    .CAT_W(CAT_W), .ADDR_W(ADDR_W), .RD_ADDR(RD_ADDR), .STB_CYCLES(STB_CYCLES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cat_code(cat_code), .id_stb(id_stb),
    .id_sync(id_sync), .q_stb(q_stb), .rd_req(rd_req), .rd_addr(rd_addr),
    .id_evt(id_evt), .rdy_n(rdy_n), .sdo_valid(sdo_valid)
);

// File: tb/sid_detector_tb.sv
// Bench for sid_detector: directed corner cases plus seeded random fields.
module sid_detector_tb_top;

    localparam int STB = 4;
    localparam logic [7:0] RA = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cat_code = '0;
    logic        id_stb = 0, id_sync = 0, id_start = 0, id_short = 0;
    logic        q_stb = 0, q_crc_ok = 0;
    logic [79:0] q_data = '0;
    logic        rd_req = 0;
    logic [7:0]  rd_addr = '0;
    logic        rdy_n, sdo, sdo_valid;

    int n_cmp = 0;
    int n_bad = 0;

    logic [80:0] exp_word = '0;
    bit          armed_m = 1'b1;

    always #4 clk = ~clk;

    sid_detector dut_i (
        .clk(clk), .rst_n(rst_n), .cat_code(cat_code), .id_stb(id_stb),
        .id_sync(id_sync), .id_start(id_start), .id_short(id_short),
        .q_stb(q_stb), .q_data(q_data), .q_crc_ok(q_crc_ok),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rdy_n(rdy_n), .sdo(sdo), .sdo_valid(sdo_valid)
    );

    task automatic check(input bit ok, input string req,
                         input logic [80:0] act, input logic [80:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit cat_match(input logic [7:0] c);
        return c[7:1] == 7'b1100000;
    endfunction

    // Expected word for a field: 2 = start, 1 = shortening, 0 = none.
    function automatic int field_kind(input logic [7:0] c, input bit s, input bit r, input bit l);
        if (!cat_match(c) || !s) return 0;
        if (r) return 2;
        if (l) return 1;
        return 0;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one field (optionally with a Q frame), then check the strobe.
    task automatic field(input logic [7:0] c, input bit s, input bit r, input bit l,
                         input bit with_q, input logic [79:0] qd, input bit qf,
                         input string req);
        int  k;
        bit  evt;
        k   = field_kind(c, s, r, l);
        evt = (k != 0) && armed_m;
        if (k == 0) armed_m = 1'b1;
        else if (armed_m) armed_m = 1'b0;
        if (evt) exp_word = (k == 2) ? {81{1'b1}} : '0;
        else if (with_q) exp_word = {qd, qf};
        cat_code = c; id_sync = s; id_start = r; id_short = l;
        id_stb = 1'b1; q_stb = with_q; q_data = qd; q_crc_ok = qf;
        @(negedge clk);
        id_stb = 1'b0; q_stb = 1'b0;
        check(rdy_n == !(evt || with_q), req, {80'd0, rdy_n}, {80'd0, !(evt || with_q)});
        idle(STB + 1);
    endtask

    // Read the word; optionally inject a Q frame mid-readout.
    task automatic read_word(input string req, input bit inject, input logic [79:0] qd);
        logic [80:0] got;
        logic [80:0] want;
        bit          vok;
        want = exp_word;
        vok  = 1'b1;
        rd_addr = RA; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        for (int i = 0; i < 81; i++) begin
            got[i] = sdo;
            if (!sdo_valid) vok = 1'b0;
            if (inject && i == 10) begin
                q_stb = 1'b1; q_data = qd; q_crc_ok = 1'b1;
                exp_word = {qd, 1'b1};
            end
            @(negedge clk);
            q_stb = 1'b0;
        end
        check(got == want, req, got, want);
        check(vok && !sdo_valid, "R9 valid window", {80'd0, vok && !sdo_valid}, 81'd1);
        idle(STB + 1);
    endtask

    function automatic logic [79:0] rnd80();
        return {$urandom(), $urandom(), $urandom()} & {80{1'b1}};
    endfunction

    initial begin
        void'($urandom(32'd20240607));
        idle(3);
        // R1: reset state
        check(rdy_n === 1'b1 && sdo_valid === 1'b0, "R1", {79'd0, rdy_n, sdo_valid}, 81'd2);
        rst_n = 1'b1;
        idle(2);

        // R3: start marker, L bit 0
        field(8'b1100_0000, 1, 1, 0, 0, '0, 0, "R3 strobe");
        read_word("R3 word", 0, '0);
        // R4 after a re-arming non-marker field, L bit 1
        field(8'b1100_0001, 0, 0, 0, 0, '0, 0, "R7 rearm");
        field(8'b1100_0001, 1, 0, 1, 0, '0, 0, "R4 strobe");
        read_word("R4 word", 0, '0);
        // R7: held marker gives one strobe
        field(8'b1100_0000, 1, 0, 1, 0, '0, 0, "R7 held");
        field(8'b1100_0000, 1, 1, 0, 0, '0, 0, "R7 held");
        field(8'b1100_0000, 1, 0, 0, 0, '0, 0, "R7 rearm");
        // R6: both bits set gives start
        field(8'b1100_0000, 1, 1, 1, 0, '0, 0, "R6 strobe");
        read_word("R6 word", 0, '0);
        field(8'b1100_0000, 0, 0, 0, 0, '0, 0, "R7 rearm");
        // R2: wrong category
        field(8'b1110_0000, 1, 1, 0, 0, '0, 0, "R2 no strobe");
        field(8'b0100_0001, 1, 0, 1, 0, '0, 0, "R2 no strobe");
        read_word("R2 word kept", 0, '0);
        // R5: no sync
        field(8'b1100_0000, 0, 1, 1, 0, '0, 0, "R5 no strobe");
        // R10: Q frame supplies word
        field(8'b0000_0000, 0, 0, 0, 1, 80'h0123_4567_89ab_cdef_1357, 0, "R10 strobe");
        read_word("R10 word", 0, '0);
        // R11: same-cycle marker and Q frame
        field(8'b1100_0000, 1, 0, 1, 1, 80'hffff_0000_ffff_0000_ffff, 1, "R11 strobe");
        read_word("R11 word", 0, '0);
        // R12: event during readout
        read_word("R12 snapshot", 1, 80'hdead_beef_cafe_f00d_5a5a);
        read_word("R12 new word", 0, '0);

        // R8: exact strobe length
        begin
            int lows;
            lows = 0;
            q_stb = 1'b1; @(negedge clk); q_stb = 1'b0;
            exp_word = {q_data, q_crc_ok};
            for (int i = 0; i < STB + 3; i++) begin
                if (!rdy_n) lows++;
                @(negedge clk);
            end
            check(lows == STB, "R8", lows, STB);
        end

        // R9: wrong address ignored
        rd_addr = RA ^ 8'h01; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(sdo_valid == 1'b0, "R9 bad addr", {80'd0, sdo_valid}, 81'd0);
        idle(2);

        // Random fields mixed with Q frames and readouts.
        for (int n = 0; n < 400; n++) begin
            logic [7:0] c;
            c = ($urandom_range(0, 3) != 0) ? {7'b1100000, 1'($urandom())} : 8'($urandom());
            field(c, 1'($urandom()), 1'($urandom()), 1'($urandom()),
                  ($urandom_range(0, 5) == 0), rnd80(), 1'($urandom()), "R7 random");
            if ($urandom_range(0, 7) == 0) read_word("R3 R4 R10 random word", 0, '0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule